// File: doc/BRIEF.md
# Fractional-Ratio Clock Divider

This block divides an input clock by a ratio that need not be a whole number. In its fractional mode, each output period is built from a whole number of input cycles, either `I` or `I+1`. A first-order phase accumulator picks between the two so that the long-run average equals `I + F/D`. For example, `I=3, F=1415, D=10000` gives an average of 3.1415 input cycles per output cycle. A companion flag shows, for every output period, whether that period is the stretched one.

A second mode divides by exactly 1.5 and uses both edges of the input clock. One flop is clocked on the rising edge and one on the falling edge. Their XOR forms the output, so no clock is gated. The output changes level after one input half-period, then after two, then after one, and so on. Each output cycle therefore spans three input half-periods.

The ratio inputs are sampled once per output period, at its first edge. Changes that arrive in the middle of a period wait for the next one. Reset is synchronous and active high. It clears the accumulator and the edge flops, so the sequence of periods after reset is fully determined.

Top module: `frdiv_top`

## Requirements
- R1: While `rst` is held high, `clk_out` and `stretch` are both 0.
- R2: With `half_mode` low and `I >= 2`, every output period lasts either `I` or `I+1` input clock cycles. An output period is measured from one rising edge of `clk_out` to the next.
- R3: With `half_mode` low and `F < D`, the first `D` output periods after reset together last exactly `I*D + F` input cycles, and exactly `F` of them are stretched.
- R4: Number the output periods after reset from p = 0. Period p lasts `I+1` cycles exactly when floor((p+1)·F/D) > floor(p·F/D). `stretch` is 1 for the whole of such a period and 0 for the whole of any other period.
- R5: In fractional mode, an output period of L input cycles starts with `clk_out` high for floor(L/2) cycles, and `clk_out` is low for the rest of the period.
- R6: With `F = 0`, every output period lasts exactly `I` cycles and `stretch` stays 0.
- R7: A change of `int_part`, `frac_num` or `frac_den` during an output period leaves that period's length unchanged. The new values apply from the next period.
- R8: With `half_mode` high, the first rising input edge after reset is released drives `clk_out` high. After that, `clk_out` is high for one input half-period and low for the next two, repeating. This gives an output period of 1.5 input cycles.
- R9: While `half_mode` is high (and from the second input edge after it rises), `stretch` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided; both edges are used in half-step mode |
| rst | input | 1 | Synchronous active-high reset |
| half_mode | input | 1 | 1 selects fixed divide-by-1.5; 0 selects the fractional divider |
| int_part | input | W_INT | Integer part I of the ratio (must be at least 2) |
| frac_num | input | W_FRAC | Fractional numerator F (must be below D) |
| frac_den | input | W_FRAC | Fractional denominator D (must be at least 1) |
| clk_out | output | 1 | Divided clock |
| stretch | output | 1 | 1 during an output period that uses I+1 input cycles |

## Verification
The bench builds the block with `W_INT = 8` and `W_FRAC = 14`. With these widths a denominator of 10000 is legal, so the 3 + 1415/10000 ratio can be run over a full cycle of the accumulator and its total checked to the exact cycle. Besides that ratio, the bench sweeps every numerator/denominator pair with D from 1 to 7 against integer parts 2 to 5. For each output period it checks the length, the high time and the stretch flag against the floor-difference formula. The 1.5 mode is checked at every input half-period, and a mid-period change of the integer part shows when new inputs are taken.

// File: rtl/frdiv_pkg.sv
package frdiv_pkg;
  // Three-step phase of the divide-by-1.5 sequencer
  typedef enum logic [1:0] {
    PH_A = 2'd0,
    PH_B = 2'd1,
    PH_C = 2'd2
  } hs_phase_e;
endpackage

// File: rtl/frdiv_phase.sv
// First-order phase accumulator: decides whether the next output
// period is stretched by one input cycle.
module frdiv_phase #(
  parameter int W_FRAC = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              adv,
  input  logic [W_FRAC-1:0] num,
  input  logic [W_FRAC-1:0] den,
  output logic              take_long
);
  localparam int W_SUM = W_FRAC + 1;

  logic [W_FRAC-1:0] acc;
  logic [W_SUM-1:0]  sum;

  always_comb begin
    sum       = {1'b0, acc} + {1'b0, num};
    take_long = (sum >= {1'b0, den});
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      acc <= '0;
    end else if (adv) begin
      if (take_long) acc <= W_FRAC'(sum - {1'b0, den});
      else           acc <= sum[W_FRAC-1:0];
    end
  end

  // Residue stays below the denominator it was reduced against
  assert_acc_below_den_R3: assert property (@(posedge clk) disable iff (rst)
    (en && adv && (num < den) && (acc < den)) |=> (acc < $past(den)));
endmodule

// File: rtl/frdiv_count.sv
// Period counter and registered waveform for the fractional mode.
module frdiv_count #(
  parameter int W_INT = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [W_INT-1:0] int_part,
  input  logic             take_long,
  output logic             adv,
  output logic             wave_q,
  output logic             long_q
);
  localparam int W_LEN = W_INT + 1;

  logic [W_LEN-1:0] cnt, len, cnt_nx, len_nx;

  always_comb begin
    adv    = en && (cnt == len - W_LEN'(1));
    len_nx = adv ? ({1'b0, int_part} + W_LEN'(take_long)) : len;
    cnt_nx = adv ? '0 : cnt + W_LEN'(1);
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt    <= '0;
      len    <= W_LEN'(1);
      wave_q <= 1'b0;
      long_q <= 1'b0;
    end else begin
      cnt    <= cnt_nx;
      len    <= len_nx;
      wave_q <= (cnt_nx < (len_nx >> 1));
      if (adv) long_q <= take_long;
    end
  end

  assert_cnt_in_len_R2: assert property (@(posedge clk) disable iff (rst)
    (len != '0) |-> (cnt < len));

  assert_len_choice_R2: assert property (@(posedge clk) disable iff (rst)
    (adv && (int_part != '0)) |=>
      ((len == {1'b0, $past(int_part)}) || (len == {1'b0, $past(int_part)} + W_LEN'(1))));

  assert_stretch_len_R4: assert property (@(posedge clk) disable iff (rst)
    (adv && en) |=> (long_q == (len != {1'b0, $past(int_part)})));
endmodule

// File: rtl/frdiv_halfstep.sv
// Divide-by-1.5 using a rising-edge flop and a falling-edge flop whose
// XOR is the output; toggle gaps of 1 and 2 half-periods alternate.
module frdiv_halfstep
  import frdiv_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tog_out
);
  hs_phase_e ph;
  logic      r_q, f_q;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      ph  <= PH_A;
      r_q <= 1'b0;
    end else begin
      if (ph != PH_B) r_q <= ~r_q;
      case (ph)
        PH_A:    ph <= PH_B;
        PH_B:    ph <= PH_C;
        default: ph <= PH_A;
      endcase
    end
  end

  always_ff @(negedge clk) begin
    if (rst || !en) f_q <= 1'b0;
    else if (ph != PH_A) f_q <= ~f_q;
  end

  assign tog_out = r_q ^ f_q;

  assert_phase_range_R8: assert property (@(posedge clk) disable iff (rst)
    ph inside {PH_A, PH_B, PH_C});
endmodule

// File: rtl/frdiv_top.sv
module frdiv_top #(
  parameter int W_INT  = 8,
  parameter int W_FRAC = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              half_mode,
  input  logic [W_INT-1:0]  int_part,
  input  logic [W_FRAC-1:0] frac_num,
  input  logic [W_FRAC-1:0] frac_den,
  output logic              clk_out,
  output logic              stretch
);
  logic frac_en, adv, take_long, wave_q, long_q, hs_out;

  assign frac_en = !half_mode;

  frdiv_phase #(.W_FRAC(W_FRAC)) u_phase (
    .clk(clk), .rst(rst), .en(frac_en), .adv(adv),
    .num(frac_num), .den(frac_den), .take_long(take_long)
  );

  frdiv_count #(.W_INT(W_INT)) u_count (
    .clk(clk), .rst(rst), .en(frac_en), .int_part(int_part),
    .take_long(take_long), .adv(adv), .wave_q(wave_q), .long_q(long_q)
  );

  frdiv_halfstep u_half (
    .clk(clk), .rst(rst), .en(half_mode), .tog_out(hs_out)
  );

  assign clk_out = half_mode ? hs_out : wave_q;
  assign stretch = long_q;

  assert_half_no_stretch_R9: assert property (@(posedge clk) disable iff (rst)
    ($past(half_mode) && half_mode) |-> !stretch);
endmodule

// File: tb/sim_frdiv_top.sv
module sim_frdiv_top;
  localparam int CLK_T = 10;
  localparam int WI    = 8;
  localparam int WF    = 14;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          half_mode = 1'b0;
  logic [WI-1:0] int_part = WI'(2);
  logic [WF-1:0] frac_num = '0;
  logic [WF-1:0] frac_den = WF'(1);
  logic          clk_out, stretch;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_T/2) clk = ~clk;

  frdiv_top #(.W_INT(WI), .W_FRAC(WF)) u0 (
    .clk(clk), .rst(rst), .half_mode(half_mode), .int_part(int_part),
    .frac_num(frac_num), .frac_den(frac_den), .clk_out(clk_out), .stretch(stretch)
  );

  task automatic check(bit ok, string req, int act, int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Holds reset for three cycles and checks the reset state (R1)
  task automatic do_reset(bit hm);
    @(negedge clk);
    rst = 1'b1;
    half_mode = hm;
    repeat (3) @(negedge clk);
    #1;
    check(clk_out == 1'b0, "R1 clk_out", int'(clk_out), 0);
    check(stretch == 1'b0, "R1 stretch", int'(stretch), 0);
  endtask

  // Runs nper output periods; int_part switches to ni during period 0 (R7)
  task automatic run_frac(int ii, int ff, int dd, int nper, int ni);
    int  p = 0, len = 0, hi = 0, tot = 0, nlong = 0, cur_i = ii;
    bit  prev = 1'b0, el = 1'b0;
    int_part = WI'(ii);
    frac_num = WF'(ff);
    frac_den = WF'(dd);
    do_reset(1'b0);
    rst = 1'b0;
    while (p < nper) begin
      @(negedge clk);
      #1;
      if (clk_out && !prev && len > 0) begin
        check(len == cur_i + int'(el), (ni != ii) ? "R7 length" : "R2 length",
              len, cur_i + int'(el));
        check(hi == len / 2, "R5 high time", hi, len / 2);
        tot += len;
        nlong += int'(el);
        p++;
        len = 0;
        hi = 0;
      end
      if (p < nper) begin
        if (len == 0) begin
          cur_i = (p == 0) ? ii : ni;
          el = (((p + 1) * ff) / dd) != ((p * ff) / dd);
          check(stretch == el, (ff == 0) ? "R6 stretch" : "R4 stretch",
                int'(stretch), int'(el));
          if (p == 0 && ni != ii) int_part = WI'(ni);
        end
        len++;
        hi += int'(clk_out);
        prev = clk_out;
      end
    end
    if (ni == ii && nper == dd) begin
      check(tot == ii * dd + ff, "R3 total cycles", tot, ii * dd + ff);
      check(nlong == ff, "R3 stretched count", nlong, ff);
    end
  endtask

  // Divide-by-1.5: one sample per input half-period (R8, R9)
  task automatic run_half();
    bit ex;
    do_reset(1'b1);
    @(posedge clk);
    #2 rst = 1'b0;
    @(negedge clk);
    #2;
    check(clk_out == 1'b0, "R8 before first edge", int'(clk_out), 0);
    for (int j = 0; j < 36; j++) begin
      if (j % 2 == 0) @(posedge clk);
      else            @(negedge clk);
      #2;
      ex = (j % 3 == 0);
      check(clk_out == ex, "R8 half-step pattern", int'(clk_out), int'(ex));
      check(stretch == 1'b0, "R9 stretch in half mode", int'(stretch), 0);
    end
  endtask

  initial begin
    for (int ii = 2; ii <= 5; ii++)
      for (int dd = 1; dd <= 7; dd++)
        for (int ff = 0; ff < dd; ff++)
          run_frac(ii, ff, dd, dd, ii);
    run_frac(3, 1415, 10000, 10000, 3);
    run_frac(4, 0, 1, 3, 6);
    run_frac(3, 2, 5, 6, 5);
    run_half();
    run_frac(2, 1, 2, 2, 2);
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    #(CLK_T * 200000);
    if (!done) begin
      done = 1'b1;
      n_vec++;
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule